// File: doc/BRIEF.md
# H-Bridge Command and Fault Manager

This block sits between a controller and the gate drivers of a full bridge with two legs. It turns two per-leg direction inputs and two disable inputs into on-enables for the high-side and low-side switch of each leg. It also owns the active-low fault flag. It takes already-resolved digital flags for supply undervoltage, overtemperature and hard short. It also takes a synchronous force-off input from a separate current-limit chopper.

Every asynchronous input passes through a two-flop synchronizer, and the switch enables come out of registers. A short or overtemperature event latches the bridge off. The latch is released only by the host releasing a disable: the active-high disable falling or the active-low disable rising. Undervoltage recovers by itself. Each leg inserts a programmable dead-time whenever its polarity reverses, so the two switches of a leg are never on together.

Top module: `hbridge_ctrl`

## Requirements
- R1: With no disable, fault or force-off active, leg A (bit 0 of each output vector) drives its high side when `dir_a_i` is 1 and its low side when it is 0. Leg B (bit 1) follows `dir_b_i` in the same way. The fault flag is high.
- R2: Equal direction inputs are legal. Both 1 turns on both high sides; both 0 turns on both low sides.
- R3: While `dis_hi_i` is 1 or `dis_lo_ni` is 0, all four enables are off, both `hiz_o` bits are 1 and `fault_no` is 0, whatever the direction inputs are.
- R4: While `uv_i` is 1, the bridge is off and `fault_no` is 0. When `uv_i` returns to 0, the commanded state and a high flag return with no other action.
- R5: A 1 on `short_i` or `ot_i` latches the bridge off with `fault_no` at 0. The latch holds after the flag returns to 0, and it holds regardless of the direction inputs.
- R6: The latch clears only on a 1-to-0 transition of the synchronized `dis_hi_i` or a 0-to-1 transition of the synchronized `dis_lo_ni`. Changes on the direction inputs leave it set.
- R7: A clearing edge that arrives while `ot_i` is still 1 leaves the latch set. A short or overtemperature flag takes priority over a clear.
- R8: Reset clears the latch. It loads the synchronizers with the disabled levels (`dis_hi` high, `dis_lo` low), so the legs are off and `fault_no` is 0 until real input values have crossed the synchronizer.
- R9: A leg's high-side and low-side enables are never 1 together. On a polarity reversal the leg spends exactly `DEAD_CYC` cycles with both off.
- R10: `chop_off_i` is taken without synchronization. It turns both legs off at the next clock edge and does not pull `fault_no` low.
- R11: A change on a synchronized input reaches the outputs at the third rising clock edge after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dir_a_i | input | 1 | Leg A direction (1 = high side) |
| dir_b_i | input | 1 | Leg B direction (1 = high side) |
| dis_hi_i | input | 1 | Disable, active high |
| dis_lo_ni | input | 1 | Disable, active low |
| uv_i | input | 1 | Supply undervoltage flag |
| ot_i | input | 1 | Overtemperature flag, hysteresis resolved |
| short_i | input | 1 | Hard-short detect flag |
| chop_off_i | input | 1 | Synchronous force-off from current-limit chopper |
| hs_en_o | output | 2 | High-side enable per leg |
| ls_en_o | output | 2 | Low-side enable per leg |
| hiz_o | output | 2 | Leg tri-stated (both switches off) |
| fault_no | output | 1 | Fault flag, active low |

## Verification
On every cycle, the assertions check that a leg's two switches never overlap and that a high side is never followed directly by a low side. They also check that a latched fault always shows on the flag, that undervoltage, overtemperature and force-off act one edge later, and that the latch persists without a clearing edge. Only the bench scenarios can show some behaviours: the exact dead-time length, the three-edge input latency, the reset-time disabled state, and the end-to-end clearing of a latch through either disable input. The same holds for the temperature flag blocking a clear.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef enum logic [1:0] {
    LEG_OFF = 2'd0,
    LEG_HI  = 2'd1,
    LEG_LO  = 2'd2
  } leg_e;

  localparam int N_LEG   = 2;
  localparam int N_ASYNC = 7;
  // bit positions of the synchronized input vector
  localparam int I_DIR_A = 0;
  localparam int I_DIR_B = 1;
  localparam int I_DISH  = 2;
  localparam int I_DISL  = 3;
  localparam int I_UV    = 4;
  localparam int I_OT    = 5;
  localparam int I_SHORT = 6;
  // reset image: disables asserted, everything else low
  localparam logic [N_ASYNC-1:0] SYNC_RST = 7'b000_0100;
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int              W       = 1,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/hb_fault.sv
module hb_fault (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dish_s_i,
  input  logic disl_s_i,
  input  logic uv_s_i,
  input  logic ot_s_i,
  input  logic short_s_i,
  output logic block_o,
  output logic fault_no
);
  logic lat_q, dish_prev_q, disl_prev_q, fault_q;
  logic dish_fall, disl_rise, trip, disabled;

  assign dish_fall = dish_prev_q & ~dish_s_i;
  assign disl_rise = ~disl_prev_q & disl_s_i;
  assign trip      = ot_s_i | short_s_i;
  assign disabled  = dish_s_i | ~disl_s_i;
  assign block_o   = disabled | uv_s_i | trip | lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q       <= 1'b0;
      dish_prev_q <= 1'b1;
      disl_prev_q <= 1'b0;
      fault_q     <= 1'b0;
    end else begin
      dish_prev_q <= dish_s_i;
      disl_prev_q <= disl_s_i;
      // trip wins over a clearing edge
      if (trip)                        lat_q <= 1'b1;
      else if (dish_fall || disl_rise) lat_q <= 1'b0;
      fault_q <= ~block_o;
    end
  end

  assign fault_no = fault_q;

  assert_latch_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lat_q |-> !fault_no);
  assert_uv_flag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uv_s_i |=> !fault_no);
  assert_hold_latch_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lat_q && !dish_fall && !disl_rise) |=> lat_q);
  assert_ot_keeps_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ot_s_i |=> lat_q);
endmodule

// File: rtl/hb_leg.sv
module hb_leg
  import hb_pkg::*;
#(
  parameter int DEAD_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  leg_e cmd_i,
  output logic hs_o,
  output logic ls_o,
  output logic hiz_o
);
  localparam int CW = $clog2(DEAD_CYC + 1);
  localparam logic [CW-1:0] DEAD_V = CW'(DEAD_CYC);
  localparam logic [CW-1:0] ONE_V  = CW'(1);

  leg_e          state_q, last_q;
  logic [CW-1:0] cnt_q;
  logic          allow;

  // re-enable is free for the same side or once the gap has elapsed
  assign allow = (last_q == LEG_OFF) || (cmd_i == last_q) || (cnt_q >= DEAD_V);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= LEG_OFF;
      last_q  <= LEG_OFF;
      cnt_q   <= DEAD_V;
    end else if (state_q != LEG_OFF) begin
      if (cmd_i != state_q) begin
        state_q <= LEG_OFF;
        cnt_q   <= ONE_V;
      end
    end else if (cmd_i != LEG_OFF && allow) begin
      state_q <= cmd_i;
      last_q  <= cmd_i;
    end else if (cnt_q < DEAD_V) begin
      cnt_q <= cnt_q + ONE_V;
    end
  end

  assign hs_o  = (state_q == LEG_HI);
  assign ls_o  = (state_q == LEG_LO);
  assign hiz_o = (state_q == LEG_OFF);

  assert_no_overlap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs_o && ls_o));
  assert_hs_gap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_o |=> !ls_o);
  assert_ls_gap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ls_o |=> !hs_o);
  assert_forced_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == LEG_OFF) |=> hiz_o);
endmodule

// File: rtl/hbridge_ctrl.sv
module hbridge_ctrl
  import hb_pkg::*;
#(
  parameter int DEAD_CYC = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dir_a_i,
  input  logic             dir_b_i,
  input  logic             dis_hi_i,
  input  logic             dis_lo_ni,
  input  logic             uv_i,
  input  logic             ot_i,
  input  logic             short_i,
  input  logic             chop_off_i,
  output logic [N_LEG-1:0] hs_en_o,
  output logic [N_LEG-1:0] ls_en_o,
  output logic [N_LEG-1:0] hiz_o,
  output logic             fault_no
);
  logic [N_ASYNC-1:0] raw, syn;
  logic [N_LEG-1:0]   dir_s;
  logic               block, off_all;

  assign raw[I_DIR_A] = dir_a_i;
  assign raw[I_DIR_B] = dir_b_i;
  assign raw[I_DISH]  = dis_hi_i;
  assign raw[I_DISL]  = dis_lo_ni;
  assign raw[I_UV]    = uv_i;
  assign raw[I_OT]    = ot_i;
  assign raw[I_SHORT] = short_i;

  hb_sync #(.W(N_ASYNC), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  hb_fault u_fault (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .dish_s_i (syn[I_DISH]),
    .disl_s_i (syn[I_DISL]),
    .uv_s_i   (syn[I_UV]),
    .ot_s_i   (syn[I_OT]),
    .short_s_i(syn[I_SHORT]),
    .block_o  (block),
    .fault_no (fault_no)
  );

  assign dir_s   = {syn[I_DIR_B], syn[I_DIR_A]};
  assign off_all = block | chop_off_i;

  for (genvar g = 0; g < N_LEG; g++) begin : g_leg
    leg_e cmd;
    assign cmd = off_all ? LEG_OFF : (dir_s[g] ? LEG_HI : LEG_LO);
    hb_leg #(.DEAD_CYC(DEAD_CYC)) u_leg (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .cmd_i (cmd),
      .hs_o  (hs_en_o[g]),
      .ls_o  (ls_en_o[g]),
      .hiz_o (hiz_o[g])
    );
  end

  assert_chop_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chop_off_i |=> (hiz_o == '1));
  assert_chop_no_flag_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!block && chop_off_i) |=> fault_no);
endmodule

// File: tb/tb_hbridge_ctrl.sv
module tb_hbridge_ctrl;
  localparam int DEAD = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic dir_a = 1'b1, dir_b = 1'b0, dis_hi = 1'b0, dis_lo_n = 1'b1;
  logic uv = 1'b0, ot = 1'b0, sh = 1'b0, chop = 1'b0;
  logic [1:0] hs, ls, hiz;
  logic fn;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  hbridge_ctrl #(.DEAD_CYC(DEAD)) dut (
    .clk_i(clk), .rst_ni(rst_n), .dir_a_i(dir_a), .dir_b_i(dir_b),
    .dis_hi_i(dis_hi), .dis_lo_ni(dis_lo_n), .uv_i(uv), .ot_i(ot),
    .short_i(sh), .chop_off_i(chop), .hs_en_o(hs), .ls_en_o(ls),
    .hiz_o(hiz), .fault_no(fn)
  );

  // {req[3:0], dis_hi, dis_lo_n, dir_b, dir_a, uv, ot, short, chop, hs[1:0], ls[1:0], fault_n}
  localparam logic [16:0] VEC [10] = '{
    {4'd1,  8'b01010000, 5'b01101},  // R1 A high, B low
    {4'd1,  8'b01100000, 5'b10011},  // R1 reversed
    {4'd2,  8'b01110000, 5'b11001},  // R2 both high
    {4'd2,  8'b01000000, 5'b00111},  // R2 both low
    {4'd3,  8'b11010000, 5'b00000},  // R3 active-high disable
    {4'd3,  8'b00010000, 5'b00000},  // R3 active-low disable
    {4'd4,  8'b01011000, 5'b00000},  // R4 undervoltage
    {4'd4,  8'b01010000, 5'b01101},  // R4 recovery
    {4'd10, 8'b01010001, 5'b00001},  // R10 force-off, flag stays high
    {4'd10, 8'b01100000, 5'b10011}   // R10 release
  };

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, logic [4:0] exp);
    logic [6:0] e, g;
    e = {exp[4:1], ~(exp[4:3] | exp[2:1]), exp[0]};
    g = {hs, ls, hiz, fn};
    total++;
    if (g !== e) begin
      bad++;
      $display("FAIL %s: got hs/ls/hiz/fn=%b expected %b", tag, g, e);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // R9 overlap monitor
  always @(negedge clk) if (rst_n && ((hs & ls) != 2'b00)) begin
    bad++;
    $display("FAIL R9: overlap hs=%b ls=%b expected no overlap", hs, ls);
  end

  initial begin
    logic [16:0] v;
    int gap;
    // R8: enabled inputs during reset, still disabled right after release
    cyc(3);
    chk("R8 in reset", 5'b00000);
    rst_n = 1'b1;
    cyc(1);
    chk("R8 after release", 5'b00000);
    cyc(12);

    for (int i = 0; i < 10; i++) begin
      v = VEC[i];
      dis_hi = v[12]; dis_lo_n = v[11]; dir_b = v[10]; dir_a = v[9];
      uv = v[8]; ot = v[7]; sh = v[6]; chop = v[5];
      cyc(12);
      chk($sformatf("R%0d vec %0d", v[16:13], i), v[4:0]);
    end

    // R11 latency: state A high, B low
    dir_a = 1; dir_b = 0; cyc(12);
    dis_hi = 1;
    cyc(2);
    chk("R11 after two edges", 5'b01101);
    cyc(1);
    chk("R11 after third edge", 5'b00000);
    dis_hi = 0; cyc(12);

    // R9 dead-time on leg A reversal
    dir_a = 0;
    cyc(3);
    gap = 0;
    while (hiz[0] && gap < 50) begin gap++; cyc(1); end
    total++;
    if (gap != DEAD || ls[0] !== 1'b1) begin
      bad++;
      $display("FAIL R9: off gap=%0d ls=%b expected gap=%0d ls=1", gap, ls[0], DEAD);
    end
    dir_a = 1; cyc(12);

    // R5 short latches; R6 direction changes do not clear
    sh = 1; cyc(4); sh = 0; cyc(12);
    chk("R5 short latched", 5'b00000);
    dir_a = 0; dir_b = 1; cyc(12);
    chk("R6 dir change keeps latch", 5'b00000);
    dis_lo_n = 0; cyc(6); dis_lo_n = 1; cyc(12);
    chk("R6 clear by dis_lo rise", 5'b10011);

    // R5 overtemperature; R7 clear blocked while still hot
    ot = 1; cyc(12);
    chk("R5 ot latched", 5'b00000);
    dis_hi = 1; cyc(6); dis_hi = 0; cyc(12);
    chk("R7 clear while hot", 5'b00000);
    ot = 0; cyc(12);
    chk("R5 latch holds after ot drops", 5'b00000);
    dis_hi = 1; cyc(6); dis_hi = 0; cyc(12);
    chk("R6 clear by dis_hi fall", 5'b10011);

    // R8: reset mid-fault clears the latch
    sh = 1; cyc(6); sh = 0; cyc(6);
    rst_n = 0; cyc(2); rst_n = 1; cyc(12);
    chk("R8 reset clears latch", 5'b10011);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule